// File: doc/BRIEF.md
# Carrier Presence Detector with Majority Filter

The block watches a one-bit, already shaped zero-cross level taken from a received carrier and decides whether a carrier near one sixteenth of the system clock is present. It synchronizes the level with two flops and detects rising edges. It times every input period in system clocks with a counter that wraps modulo 18. Each period is judged good or bad against an acceptance window.

A period is good when its length modulo 18 lands in 15..17 clocks. This rule also admits sub-harmonics up to a bounded length. A silent input is turned into a steady stream of bad judgements by a timeout. The judgements feed a 15-deep history. A vote with hysteresis over that history drives an active-low presence output.

The detector has no data stream at its edge. The input is a free-running level and the output is a plain status level, so there is no valid/ready handshake and no back-pressure.

Top module: `carrier_detect`

## Requirements
- R1: While `rst_n` is low and after it rises, `det_n` is high, the history holds no good judgements and the period counters are cleared; the first rising edge after reset or after a timeout starts timing and produces no judgement.
- R2: A period of 15, 16 or 17 clocks between successive rising edges of `zc_in` is judged good; periods of 14 and 18 clocks are judged bad.
- R3: A period of 18n+15, 18n+16 or 18n+17 clocks is judged good for every n from 0 to 12; lengths of that form with n = 13 (for example 250) are judged bad.
- R4: `det_n` goes low once at least 9 of the last 15 judgements are good; starting from a cleared history, 8 good judgements leave it high and the 9th pulls it low.
- R5: `det_n` goes high once at most 6 of the last 15 judgements are good; starting from 15 good judgements, the 9th consecutive bad judgement releases it.
- R6: With 7 or 8 good judgements among the last 15, `det_n` keeps its previous value.
- R7: When 252 clocks pass without a rising edge, one bad judgement is logged, and another is logged after every further 252 silent clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the nominal carrier period is 16 of its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_in | input | 1 | Shaped zero-cross level of the received carrier, asynchronous |
| det_n | output | 1 | Low while a carrier is judged present |

## Verification
The bench pushes periods just inside and just outside the window (14, 15, 17, 18 clocks) and the longest admitted sub-harmonic against the shortest refused one. A design that compares the raw length instead of the wrapped one would refuse 232 clocks, and one without a length cap would accept 250. The vote thresholds are probed one judgement either side of 9 and of 6, so an off-by-one in the population count or a missing hysteresis band shows up as an early or late change of `det_n`. Long silences are timed between the 8th and 9th timeout, which catches a timeout that fires once only, fires at the wrong interval, or never fires.

// File: rtl/cd_pkg.sv
package cd_pkg;
  // carrier period geometry
  localparam int unsigned CD_MOD    = 18;
  localparam int unsigned CD_WIN_LO = 15;
  localparam int unsigned CD_WIN_HI = 17;
  localparam int unsigned CD_N_MAX  = 12;
  // vote geometry
  localparam int unsigned CD_DEPTH  = 15;
  localparam int unsigned CD_ON_TH  = 9;
  localparam int unsigned CD_OFF_TH = 6;

  // one per-period judgement
  typedef struct packed {
    logic stb;
    logic ok;
  } cd_judge_t;
endpackage

// File: rtl/cd_sync_edge.sv
module cd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], level_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cd_cycle_meter.sv
module cd_cycle_meter
  import cd_pkg::*;
#(
  parameter int unsigned MOD    = CD_MOD,
  parameter int unsigned WIN_LO = CD_WIN_LO,
  parameter int unsigned WIN_HI = CD_WIN_HI,
  parameter int unsigned N_MAX  = CD_N_MAX
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise_i,
  output cd_judge_t judge_o
);
  localparam int unsigned MAX_LEN = MOD * N_MAX + WIN_HI;
  localparam int unsigned TIMEOUT = MOD * (N_MAX + 1) + WIN_HI;
  localparam int unsigned PH_W    = $clog2(MOD);
  localparam int unsigned SPAN_W  = $clog2(TIMEOUT + 2);
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(MOD - 1);
  localparam logic [PH_W-1:0]   LO_K     = PH_W'(WIN_LO);
  localparam logic [PH_W-1:0]   HI_K     = PH_W'(WIN_HI);
  localparam logic [SPAN_W-1:0] MAXLEN_K = SPAN_W'(MAX_LEN);
  localparam logic [SPAN_W-1:0] TMO_K    = SPAN_W'(TIMEOUT);

  logic [PH_W-1:0]   ph_q;
  logic [SPAN_W-1:0] span_q;
  logic              armed_q;
  logic [PH_W-1:0]   len_mod;
  logic [SPAN_W-1:0] len_full;
  logic              in_win;
  logic              len_ok;
  logic              tmo;
  cd_judge_t         judge_q;

  // length of the period ending at this edge, wrapped and unwrapped
  always_comb begin
    len_mod  = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    len_full = span_q + 1'b1;
    in_win   = (len_mod >= LO_K) && (len_mod <= HI_K);
    len_ok   = (len_full <= MAXLEN_K);
    tmo      = !rise_i && (span_q == TMO_K);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      span_q  <= '0;
      armed_q <= 1'b0;
      judge_q <= '0;
    end else if (rise_i) begin
      ph_q        <= '0;
      span_q      <= '0;
      armed_q     <= 1'b1;
      judge_q.stb <= armed_q;
      judge_q.ok  <= armed_q && in_win && len_ok;
    end else if (tmo) begin
      ph_q        <= '0;
      span_q      <= '0;
      armed_q     <= 1'b0;
      judge_q.stb <= 1'b1;
      judge_q.ok  <= 1'b0;
    end else begin
      ph_q        <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      span_q      <= span_q + 1'b1;
      judge_q.stb <= 1'b0;
      judge_q.ok  <= 1'b0;
    end
  end

  assign judge_o = judge_q;

  // R7
  span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    span_q <= TMO_K);

  // R1
  good_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !armed_q) |=> !judge_q.ok);

  // R7
  tmo_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (judge_q.stb && !judge_q.ok && span_q == '0));
endmodule

// File: rtl/cd_majority.sv
module cd_majority
  import cd_pkg::*;
#(
  parameter int unsigned DEPTH  = CD_DEPTH,
  parameter int unsigned ON_TH  = CD_ON_TH,
  parameter int unsigned OFF_TH = CD_OFF_TH
) (
  input  logic      clk,
  input  logic      rst_n,
  input  cd_judge_t judge_i,
  output logic      det_n_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] ON_K  = CNT_W'(ON_TH);
  localparam logic [CNT_W-1:0] OFF_K = CNT_W'(OFF_TH);

  logic [DEPTH-1:0] hist_q;
  logic [CNT_W-1:0] ones;
  logic             det_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else if (judge_i.stb) hist_q <= {hist_q[DEPTH-2:0], judge_i.ok};
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < DEPTH; i++) ones = ones + CNT_W'(hist_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_n_q <= 1'b1;
    else if (ones >= ON_K) det_n_q <= 1'b0;
    else if (ones <= OFF_K) det_n_q <= 1'b1;
  end

  assign det_n_o = det_n_q;

  // R4
  assert_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_n_q) |-> $past(ones) >= ON_K);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_n_q) |-> $past(ones) <= OFF_K);

  // R6
  hold_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ones > OFF_K && ones < ON_K) |=> $stable(det_n_q));

  // R4
  hist_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !judge_i.stb |=> $stable(hist_q));
endmodule

// File: rtl/carrier_detect.sv
module carrier_detect
  import cd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic zc_in,
  output logic det_n
);
  logic      rise;
  cd_judge_t judge;

  cd_sync_edge #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (zc_in),
    .rise_o  (rise)
  );

  cd_cycle_meter #(
    .MOD    (CD_MOD),
    .WIN_LO (CD_WIN_LO),
    .WIN_HI (CD_WIN_HI),
    .N_MAX  (CD_N_MAX)
  ) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise),
    .judge_o (judge)
  );

  cd_majority #(
    .DEPTH  (CD_DEPTH),
    .ON_TH  (CD_ON_TH),
    .OFF_TH (CD_OFF_TH)
  ) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .judge_i (judge),
    .det_n_o (det_n)
  );
endmodule

// File: tb/carrier_detect_tb_top.sv
module carrier_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_in = 1'b0;
  logic det_n;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  carrier_detect dut_i (.clk(clk), .rst_n(rst_n), .zc_in(zc_in), .det_n(det_n));

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: det_n actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    zc_in = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // n rising edges spaced len clocks apart
  task automatic train(input int len, input int n);
    for (int i = 0; i < n; i++) begin
      zc_in = 1'b1;
      repeat (len / 2) @(negedge clk);
      zc_in = 1'b0;
      repeat (len - len / 2) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    zc_in = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(det_n, 1'b1, "R1 during reset");
    do_reset();
    check(det_n, 1'b1, "R1 after reset");
    train(16, 16);
    settle();
    check(det_n, 1'b0, "R1 setup carrier");
    do_reset();
    check(det_n, 1'b1, "R1 reset drops detect");
    // history cleared: 8 good after reset must not assert
    train(16, 9);
    settle();
    check(det_n, 1'b1, "R1 history cleared");
  endtask

  task automatic t_threshold();
    do_reset(); train(16, 9);  settle(); check(det_n, 1'b1, "R4 eight good");
    do_reset(); train(16, 10); settle(); check(det_n, 1'b0, "R4 nine good");
  endtask

  task automatic t_window();
    do_reset(); train(15, 10); settle(); check(det_n, 1'b0, "R2 len 15");
    do_reset(); train(17, 10); settle(); check(det_n, 1'b0, "R2 len 17");
    do_reset(); train(14, 16); settle(); check(det_n, 1'b1, "R2 len 14");
    do_reset(); train(18, 16); settle(); check(det_n, 1'b1, "R2 len 18");
  endtask

  task automatic t_subharm();
    do_reset(); train(34, 10);  settle(); check(det_n, 1'b0, "R3 len 34");
    do_reset(); train(232, 10); settle(); check(det_n, 1'b0, "R3 len 232");
    do_reset(); train(250, 10); settle(); check(det_n, 1'b1, "R3 len 250");
  endtask

  task automatic t_release();
    // 16 good then 8 bad: 7 good left, band holds low
    do_reset(); train(16, 16); train(14, 9);  settle();
    check(det_n, 1'b0, "R6 seven good holds");
    // 9th bad releases
    do_reset(); train(16, 16); train(14, 10); settle();
    check(det_n, 1'b1, "R5 six good releases");
  endtask

  task automatic t_timeout();
    do_reset(); train(16, 16);
    repeat (2100) @(negedge clk);
    check(det_n, 1'b0, "R7 eight timeouts");
    repeat (250) @(negedge clk);
    check(det_n, 1'b1, "R7 ninth timeout");
    // recovery after silence
    train(16, 10); settle();
    check(det_n, 1'b0, "R7 recover after silence");
  endtask

  initial begin
    t_reset();
    t_threshold();
    t_window();
    t_subharm();
    t_release();
    t_timeout();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 200000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule